// File: doc/BRIEF.md
# DMA Transfer Length Down-Counter

This block tracks how many bytes remain in a DMA data transfer on a parallel storage bus controller. Software writes a 16-bit start length into two byte-wide register locations, low byte first. Each DMA command copies that start length into a working counter. The counter then counts down as data moves. A byte transfer takes one from it and a word transfer takes two. When the counter reaches zero it raises a terminal-count output, and the transfer is done.

Reads at the same two locations return the working counter rather than the start length. The start length is never cleared by any reset. A repeated transfer of the same size therefore only needs another DMA command. A programmed length of zero stands for the largest transfer, 65536 bytes. The strobe that counts a transfer depends on whether the controller is acting as target or initiator, on the data direction, and, for initiator input, on whether the transfer is synchronous. The DMA acknowledge input counts on its rising edge. The request-count and acknowledge-count inputs are single-cycle pulses.

Top module: `xfer_count_unit`

## Requirements
- R1: A write with reg_addr=0 sets start bits 7:0 and a write with reg_addr=1 sets start bits 15:8. A read at reg_addr=0 or 1 returns bits 7:0 or 15:8 of the working counter, never the start length.
- R2: A dma_cmd pulse loads the start length into the working counter at the next clock edge.
- R3: While not at terminal count, a selected strobe lowers the counter by 1 when word_xfer=0 and by 2 when word_xfer=1.
- R4: A start length of zero loads 65536. Both read bytes then show 0 with term_cnt low, and one byte transfer later they show 0xFFFF.
- R5: term_cnt is high exactly while the counter is zero after a load. A new load of a nonzero length clears it.
- R6: Strobes have no effect while term_cnt is high. A word transfer with 1 remaining leaves 0 rather than wrapping.
- R7: Neither rst_n nor soft_rst changes the start length, so a dma_cmd after either reloads the last programmed value.
- R8: rst_n and a soft_rst pulse both clear the working counter to 0 with term_cnt low.
- R9: With role_target=1, a rising edge of dack counts when phase_in=1, and a req_cnt pulse counts when phase_in=0. No other strobe counts.
- R10: With role_target=0, phase_in=0 counts dack edges. phase_in=1 with sync_xfer=1 counts dack edges. phase_in=1 with sync_xfer=0 counts ack_cnt pulses. No other strobe counts.
- R11: dack held high for several cycles counts only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset pulse |
| reg_addr | input | 1 | Byte select: 0 low, 1 high |
| reg_wr | input | 1 | Write strobe for the start length |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Selected byte of the working counter |
| dma_cmd | input | 1 | DMA command issued; loads the counter |
| role_target | input | 1 | 1 target, 0 initiator |
| phase_in | input | 1 | 1 data-in phase, 0 data-out phase |
| sync_xfer | input | 1 | 1 synchronous transfer |
| dack | input | 1 | DMA acknowledge level; rising edge counts |
| req_cnt | input | 1 | Request-count pulse |
| ack_cnt | input | 1 | Acknowledge-count pulse |
| word_xfer | input | 1 | 1 when the transfer is a word |
| term_cnt | output | 1 | Terminal count reached |

## Verification
A wrong working count shows up on reg_rdata one cycle after the strobe or load that produced it. A wrongly selected strobe appears as a count that moved when it should not have, or that stayed when it should have moved, and it is visible in the next read. A lost start length appears only at the next dma_cmd, so the bench reloads after each kind of reset. Wrap or saturation faults show up at term_cnt and in the read bytes in the cycle after the final decrement.

// File: rtl/xcu_pkg.sv
package xcu_pkg;

  typedef enum logic [1:0] {
    SRC_DACK_EDGE = 2'd0,
    SRC_REQ_PULSE = 2'd1,
    SRC_ACK_PULSE = 2'd2
  } strobe_src_e;

  // Role/phase to counting-strobe source
  function automatic strobe_src_e pick_src(input logic is_target,
                                           input logic is_in,
                                           input logic is_sync);
    strobe_src_e s;
    if (is_target) begin
      s = is_in ? SRC_DACK_EDGE : SRC_REQ_PULSE;
    end else if (is_in && !is_sync) begin
      s = SRC_ACK_PULSE;
    end else begin
      s = SRC_DACK_EDGE;
    end
    return s;
  endfunction

endpackage

// File: rtl/xcu_host_regs.sv
module xcu_host_regs #(
  parameter int CNT_W  = 16,
  localparam int NBYTE = CNT_W / 8,
  localparam int AW    = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
  input  logic             clk,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  input  logic [CNT_W:0]   cur_cnt,
  output logic [CNT_W-1:0] start_val,
  output logic [7:0]       reg_rdata
);

  logic [7:0] lane_q [NBYTE];
  logic [7:0] lane_d [NBYTE];
  logic       lane_en [NBYTE];

  // Start length lanes: no reset, value kept across all resets
  for (genvar g = 0; g < NBYTE; g++) begin : g_lane
    always_comb begin
      lane_en[g] = reg_wr && (reg_addr == AW'(g));
      lane_d[g]  = lane_en[g] ? reg_wdata : lane_q[g];
    end

    always_ff @(posedge clk) begin
      lane_q[g] <= lane_d[g];
    end

    assign start_val[8*g +: 8] = lane_q[g];
  end

  // Reads return the working counter
  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < NBYTE; i++) begin
      if (reg_addr == AW'(i)) reg_rdata = cur_cnt[8*i +: 8];
    end
  end

endmodule

// File: rtl/xcu_strobe_sel.sv
module xcu_strobe_sel #(
  parameter bit DACK_ACT_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic role_target,
  input  logic phase_in,
  input  logic sync_xfer,
  input  logic dack,
  input  logic req_cnt,
  input  logic ack_cnt,
  output logic dec_strobe
);
  import xcu_pkg::*;

  logic        dack_act;
  logic        dack_q;
  logic        dack_d;
  logic        dack_edge;
  strobe_src_e src;

  if (DACK_ACT_HIGH) begin : g_hi
    assign dack_act = dack;
  end else begin : g_lo
    assign dack_act = ~dack;
  end

  always_comb begin
    dack_d    = dack_act;
    dack_edge = dack_act && !dack_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dack_q <= 1'b0;
    else        dack_q <= dack_d;
  end

  always_comb begin
    src = pick_src(role_target, phase_in, sync_xfer);
    unique case (src)
      SRC_DACK_EDGE: dec_strobe = dack_edge;
      SRC_REQ_PULSE: dec_strobe = req_cnt;
      SRC_ACK_PULSE: dec_strobe = ack_cnt;
      default:       dec_strobe = 1'b0;
    endcase
  end

endmodule

// File: rtl/xcu_down_counter.sv
module xcu_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic             word,
  output logic [CNT_W:0]   cnt,
  output logic             tc
);

  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W:0] cnt_q, cnt_d;
  logic           armed_q, armed_d;
  logic [CNT_W:0] step;
  logic           cnt_en;

  assign tc = armed_q && (cnt_q == '0);

  always_comb begin
    step    = word ? (CNT_W+1)'(2) : (CNT_W+1)'(1);
    cnt_d   = cnt_q;
    armed_d = armed_q;
    cnt_en  = 1'b0;
    if (clr) begin
      cnt_d   = '0;
      armed_d = 1'b0;
      cnt_en  = 1'b1;
    end else if (load) begin
      cnt_d   = (load_val == '0) ? FULL : {1'b0, load_val};
      armed_d = 1'b1;
      cnt_en  = 1'b1;
    end else if (dec && !tc) begin
      cnt_d  = (cnt_q < step) ? '0 : (cnt_q - step);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit #(
  parameter int CNT_W         = 16,
  parameter bit DACK_ACT_HIGH = 1'b1,
  localparam int NBYTE        = CNT_W / 8,
  localparam int AW           = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          dma_cmd,
  input  logic          role_target,
  input  logic          phase_in,
  input  logic          sync_xfer,
  input  logic          dack,
  input  logic          req_cnt,
  input  logic          ack_cnt,
  input  logic          word_xfer,
  output logic          term_cnt
);

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [CNT_W-1:0] start_val;
  logic [CNT_W:0]   cur_cnt;
  logic             dec_strobe;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  xcu_host_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .cur_cnt   (cur_cnt),
    .start_val (start_val),
    .reg_rdata (reg_rdata)
  );

  xcu_strobe_sel #(.DACK_ACT_HIGH(DACK_ACT_HIGH)) u_sel (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .role_target (role_target),
    .phase_in    (phase_in),
    .sync_xfer   (sync_xfer),
    .dack        (dack),
    .req_cnt     (req_cnt),
    .ack_cnt     (ack_cnt),
    .dec_strobe  (dec_strobe)
  );

  xcu_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (soft_rst),
    .load     (dma_cmd),
    .load_val (start_val),
    .dec      (dec_strobe),
    .word     (word_xfer),
    .cnt      (cur_cnt),
    .tc       (term_cnt)
  );

endmodule

// File: rtl/xcu_checker.sv
module xcu_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             soft_rst,
  input logic             dma_cmd,
  input logic             dec_strobe,
  input logic             word_xfer,
  input logic [CNT_W-1:0] start_val,
  input logic [CNT_W:0]   cur_cnt,
  input logic             term_cnt
);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!soft_rst && dma_cmd && start_val != '0) |=> (cur_cnt == {1'b0, $past(start_val)}));

  assert_byte_dec_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!soft_rst && !dma_cmd && dec_strobe && !word_xfer && !term_cnt)
      |=> (cur_cnt == $past(cur_cnt) - 1'b1));

  assert_zero_full_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!soft_rst && dma_cmd && start_val == '0) |=> (cur_cnt == {1'b1, {CNT_W{1'b0}}} && !term_cnt));

  assert_tc_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (term_cnt && !dma_cmd && !soft_rst) |=> term_cnt);

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!dma_cmd) |=> (cur_cnt <= $past(cur_cnt)));

  assert_soft_clear_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_rst |=> (cur_cnt == '0 && !term_cnt));

endmodule

bind xfer_count_unit xcu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .soft_rst   (soft_rst),
  .dma_cmd    (dma_cmd),
  .dec_strobe (dec_strobe),
  .word_xfer  (word_xfer),
  .start_val  (start_val),
  .cur_cnt    (cur_cnt),
  .term_cnt   (term_cnt)
);

// File: tb/sim_xfer_count_unit.sv
`timescale 1ns/1ps
module sim_xfer_count_unit;

  logic clk = 1'b0;
  logic rst_n, soft_rst, reg_addr, reg_wr, dma_cmd;
  logic role_target, phase_in, sync_xfer, dack, req_cnt, ack_cnt, word_xfer;
  logic [7:0] reg_wdata, reg_rdata;
  logic term_cnt;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xfer_count_unit u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_cmd(dma_cmd), .role_target(role_target), .phase_in(phase_in),
    .sync_xfer(sync_xfer), .dack(dack), .req_cnt(req_cnt), .ack_cnt(ack_cnt),
    .word_xfer(word_xfer), .term_cnt(term_cnt)
  );

  // {target, phase_in, sync, dack, req, ack, word, expected decrement[1:0]}
  localparam int NV = 14;
  localparam logic [8:0] VEC [NV] = '{
    9'b1_1_0_1_0_0_0_01, // R9 target in, dack edge, byte
    9'b1_1_0_1_0_0_1_10, // R9 target in, dack edge, word
    9'b1_1_0_0_1_1_0_00, // R9 target in, req/ack ignored
    9'b1_0_0_0_1_0_0_01, // R9 target out, req pulse
    9'b1_0_0_1_0_0_0_00, // R9 target out, dack ignored
    9'b1_0_1_0_0_1_0_00, // R9 target out, ack ignored
    9'b1_0_0_0_1_0_1_10, // R9 target out, req word
    9'b0_1_1_1_0_0_0_01, // R10 init sync in, dack edge
    9'b0_1_1_0_1_1_0_00, // R10 init sync in, req/ack ignored
    9'b0_1_0_0_0_1_0_01, // R10 init async in, ack pulse
    9'b0_1_0_1_1_0_0_00, // R10 init async in, dack/req ignored
    9'b0_0_0_1_0_0_1_10, // R10 init out, dack edge word
    9'b0_0_1_0_1_1_0_00, // R10 init out, req/ack ignored
    9'b0_1_0_0_0_1_1_10  // R10 init async in, ack word
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_start(input logic [15:0] v);
    wr(1'b0, v[7:0]);
    wr(1'b1, v[15:8]);
  endtask

  task automatic cmd();
    dma_cmd = 1'b1;
    @(negedge clk);
    dma_cmd = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    reg_addr = 1'b0; #1 v[7:0] = reg_rdata;
    reg_addr = 1'b1; #1 v[15:8] = reg_rdata;
    reg_addr = 1'b0;
  endtask

  task automatic strobe(input logic dk, input logic rq, input logic ak, input logic wd);
    dack = dk; req_cnt = rq; ack_cnt = ak; word_xfer = wd;
    @(negedge clk);
    dack = 1'b0; req_cnt = 1'b0; ack_cnt = 1'b0; word_xfer = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; soft_rst = 0; reg_addr = 0; reg_wr = 0; reg_wdata = 0;
    dma_cmd = 0; role_target = 1; phase_in = 1; sync_xfer = 0;
    dack = 0; req_cnt = 0; ack_cnt = 0; word_xfer = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd16(v); check("R8 reset count", v, 16'h0);
    check("R8 reset tc", term_cnt, 1'b0);

    set_start(16'h1234);
    rd16(v); check("R1 read shows counter not start", v, 16'h0);
    cmd();
    rd16(v); check("R2 load", v, 16'h1234);

    // Table walk: reload 1000 before each vector
    set_start(16'd1000);
    for (int i = 0; i < NV; i++) begin
      role_target = VEC[i][8]; phase_in = VEC[i][7]; sync_xfer = VEC[i][6];
      cmd();
      strobe(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      rd16(v);
      check(VEC[i][8] ? "R9/R3 vector" : "R10/R3 vector", v, 16'd1000 - VEC[i][1:0]);
    end

    // R11: held dack counts once
    role_target = 1; phase_in = 1;
    cmd();
    dack = 1'b1;
    repeat (4) @(negedge clk);
    dack = 1'b0;
    @(negedge clk);
    rd16(v); check("R11 held dack", v, 16'd999);

    // R5/R6: terminal count and ignore
    role_target = 1; phase_in = 0;
    set_start(16'd3);
    cmd();
    check("R5 tc low after load", term_cnt, 1'b0);
    strobe(0, 1, 0, 0);
    strobe(0, 1, 0, 1);
    rd16(v); check("R3 down to zero", v, 16'h0);
    check("R5 tc at zero", term_cnt, 1'b1);
    strobe(0, 1, 0, 0);
    strobe(0, 1, 0, 1);
    rd16(v); check("R6 ignored at tc", v, 16'h0);
    check("R6 tc stays", term_cnt, 1'b1);
    cmd();
    check("R5 reload clears tc", term_cnt, 1'b0);

    set_start(16'd1);
    cmd();
    strobe(0, 1, 0, 1);
    rd16(v); check("R6 word from 1 saturates", v, 16'h0);
    check("R6 tc after saturate", term_cnt, 1'b1);

    // R4: zero means 65536
    set_start(16'h0000);
    cmd();
    rd16(v); check("R4 full load reads 0", v, 16'h0);
    check("R4 tc low on full load", term_cnt, 1'b0);
    strobe(0, 1, 0, 0);
    rd16(v); check("R4 one byte after full", v, 16'hFFFF);

    // R7/R8: resets keep start
    set_start(16'h0050);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    rd16(v); check("R8 soft reset count", v, 16'h0);
    check("R8 soft reset tc", term_cnt, 1'b0);
    cmd();
    rd16(v); check("R7 start kept over soft reset", v, 16'h0050);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd16(v); check("R8 hard reset count", v, 16'h0);
    cmd();
    rd16(v); check("R7 start kept over hard reset", v, 16'h0050);

    finish_run();
  end

endmodule